// File: doc/BRIEF.md
# Step Attenuator Control Latch

This block is the digital front end of a six-bit, binary-weighted step attenuator. It takes a parallel control word, a latch-enable strobe and a two-bit power-up selector, all asynchronous to the system clock. From these it drives a registered attenuation state that a switch network downstream decodes one bit per stage. The state value counts half-decibel steps, so bit 0 is worth 0.5 dB and bit 5 is worth 16 dB.

The strobe level selects the mode. While the strobe is high the block is transparent and the state follows the control word. When the strobe falls, the word present just before the fall is held until the next strobe. In the first cycle after reset, a low strobe loads one of four presets chosen by the selector pins. A high strobe at that point gives normal transparent operation, and the selector is ignored. An optional monitor measures the strobe pulse width and the data setup and hold around the strobe edges in system clocks. It raises a sticky flag when any of these is shorter than the configured window.

Top module: `step_atten_ctrl`

## Requirements
- R1: While reset is held, `atten_state` is 0 (reference attenuation) and `timing_viol` is 0.
- R2: At the first clock after reset with the strobe low and `pwr_sel` = 00, the state becomes 8 dB, which is code 010000 (16 half-steps).
- R3: With the strobe low at that first clock, `pwr_sel` = 01 gives 16 dB (code 100000) and `pwr_sel` = 10 gives 31 dB (code 111110).
- R4: With the strobe low at that first clock and `pwr_sel` = 11, the state is taken from `ctrl_word`.
- R5: With the strobe high at that first clock, `pwr_sel` is ignored and the state equals `ctrl_word`.
- R6: While `latch_en` is high, every change on `ctrl_word` reaches `atten_state` no later than three clocks after it is applied.
- R7: While `latch_en` is low and no falling strobe is being processed, changes on `ctrl_word` leave `atten_state` unchanged.
- R8: A falling strobe loads the word that was present one synchronized cycle before the fall, even if the word changes together with the fall.
- R9: After the first post-reset cycle, `pwr_sel` has no effect on `atten_state` until the next reset.
- R10: A synchronized strobe high time shorter than `CYC_PER_WIN` clocks sets `timing_viol`.
- R11: A word change within `CYC_PER_WIN` clocks before a rising strobe, or within `CYC_PER_WIN` clocks after a falling strobe, sets `timing_viol`. A transaction with clean margins does not set it.
- R12: `timing_viol` stays set until a cycle with `viol_clr` high and no new violation. That cycle clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctrl_word | input | WORD_W | Asynchronous attenuation control word, LSB = 0.5 dB |
| latch_en | input | 1 | Asynchronous strobe: high = transparent, falling edge = capture |
| pwr_sel | input | 2 | Asynchronous power-up preset selector |
| viol_clr | input | 1 | Clears the sticky timing flag |
| atten_state | output | WORD_W | Registered attenuation state |
| timing_viol | output | 1 | Sticky strobe timing violation flag |

## Verification
A falling strobe and a change of the control word can land in the same synchronized cycle. The capture must then take the older word, and the hold monitor must flag the same event. The bench drops `latch_en` and applies a new `ctrl_word` on the same clock. It then expects the pre-fall word in `atten_state` and a raised `timing_viol`. A second case raises the strobe together with a word change. That case checks that the transparent path shows the new word while the setup check fires.

// File: rtl/satt_pkg.sv
package satt_pkg;

   typedef enum logic [1:0] {
      PU_8DB  = 2'b00,
      PU_16DB = 2'b01,
      PU_31DB = 2'b10,
      PU_PINS = 2'b11
   } pu_sel_e;

   // Preset attenuation in half-dB steps; PU_PINS is resolved by the caller.
   function automatic int unsigned preset_halfsteps(input pu_sel_e sel);
      case (sel)
         PU_8DB:  return 16;
         PU_16DB: return 32;
         PU_31DB: return 62;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/satt_sync.sv
module satt_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("satt_sync: STAGES must be at least 2");
   end

   logic [W-1:0] pipe [STAGES];

   always_ff @(posedge clk) pipe[0] <= d;

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) pipe[i] <= pipe[i-1];
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/satt_edge_align.sv
module satt_edge_align #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         le_s,
   input  logic [W-1:0] word_s,
   output logic         le_fall,
   output logic [W-1:0] word_cap
);
   logic         le_q;
   logic [W-1:0] word_q;

   // Delay line: the word one cycle older than the edge is the one seen with the strobe still high.
   always_ff @(posedge clk) begin
      le_q   <= le_s;
      word_q <= word_s;
   end

   assign le_fall  = le_q & ~le_s;
   assign word_cap = word_q;
endmodule

// File: rtl/satt_state_reg.sv
module satt_state_reg
   import satt_pkg::*;
#(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         le_s,
   input  logic         le_fall,
   input  logic [W-1:0] word_s,
   input  logic [W-1:0] word_cap,
   input  logic [1:0]   sel_s,
   output logic [W-1:0] state
);
   localparam logic [W-1:0] CODE_8DB  = W'(preset_halfsteps(PU_8DB));
   localparam logic [W-1:0] CODE_16DB = W'(preset_halfsteps(PU_16DB));
   localparam logic [W-1:0] CODE_31DB = W'(preset_halfsteps(PU_31DB));

   logic         init_pend;
   logic [W-1:0] preset_val;
   logic [W-1:0] state_nx;

   always_comb begin
      case (pu_sel_e'(sel_s))
         PU_8DB:  preset_val = CODE_8DB;
         PU_16DB: preset_val = CODE_16DB;
         PU_31DB: preset_val = CODE_31DB;
         default: preset_val = word_s;
      endcase
   end

   always_comb begin
      state_nx = state;
      if (init_pend)    state_nx = le_s ? word_s : preset_val;
      else if (le_s)    state_nx = word_s;
      else if (le_fall) state_nx = word_cap;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= '0;
         init_pend <= 1'b1;
      end else begin
         state     <= state_nx;
         init_pend <= 1'b0;
      end
   end

   a_r2_preset_8db: assert property (@(posedge clk) disable iff (!rst_n)
      (init_pend && !le_s && sel_s == 2'b00) |=> state == W'(16));
   a_r5_boot_direct: assert property (@(posedge clk) disable iff (!rst_n)
      (init_pend && le_s) |=> state == $past(word_s));
   a_r6_direct_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_pend && le_s) |=> state == $past(word_s));
   a_r7_latched_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_pend && !le_s && !le_fall) |=> $stable(state));
   a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_pend && le_fall) |=> state == $past(word_cap));
endmodule

// File: rtl/satt_timing_mon.sv
module satt_timing_mon #(
   parameter int W           = 6,
   parameter int CYC_PER_WIN = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         le_s,
   input  logic [W-1:0] word_s,
   input  logic         viol_clr,
   output logic         viol
);
   localparam int CW = $clog2(CYC_PER_WIN + 1);
   localparam logic [CW-1:0] WIN = CW'(CYC_PER_WIN);

   logic          le_p;
   logic [W-1:0]  word_p;
   logic          armed;
   logic [CW-1:0] hi_cnt, quiet_cnt, hold_cnt;
   logic          chg, rise, fall;
   logic          short_pulse, setup_bad, hold_bad, any_bad;

   always_ff @(posedge clk) begin
      le_p   <= le_s;
      word_p <= word_s;
   end

   assign chg  = armed && (word_s != word_p);
   assign rise = armed && le_s && !le_p;
   assign fall = armed && !le_s && le_p;

   assign short_pulse = fall && (hi_cnt < WIN);
   assign setup_bad   = rise && (chg || quiet_cnt < WIN);
   assign hold_bad    = chg && (fall || hold_cnt != '0);
   assign any_bad     = short_pulse || setup_bad || hold_bad;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed     <= 1'b0;
         hi_cnt    <= '0;
         quiet_cnt <= WIN;
         hold_cnt  <= '0;
         viol      <= 1'b0;
      end else begin
         armed <= 1'b1;
         if (!le_s)             hi_cnt <= '0;
         else if (hi_cnt < WIN) hi_cnt <= hi_cnt + 1'b1;
         if (chg)                  quiet_cnt <= '0;
         else if (quiet_cnt < WIN) quiet_cnt <= quiet_cnt + 1'b1;
         if (fall)                 hold_cnt <= WIN;
         else if (hold_cnt != '0)  hold_cnt <= hold_cnt - 1'b1;
         if (any_bad)       viol <= 1'b1;
         else if (viol_clr) viol <= 1'b0;
      end
   end

   a_r10_short_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      short_pulse |=> viol);
   a_r11_window: assert property (@(posedge clk) disable iff (!rst_n)
      (setup_bad || hold_bad) |=> viol);
   a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (viol && !viol_clr) |=> viol);
   a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_clr && !any_bad) |=> !viol);
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl #(
   parameter int WORD_W      = 6,
   parameter int SYNC_STAGES = 2,
   parameter int CYC_PER_WIN = 4,
   parameter bit CHECK_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] ctrl_word,
   input  logic              latch_en,
   input  logic [1:0]        pwr_sel,
   input  logic              viol_clr,
   output logic [WORD_W-1:0] atten_state,
   output logic              timing_viol
);
   localparam int SYNC_W = WORD_W + 3;

   if (WORD_W < 6) begin : g_bad_width
      $error("step_atten_ctrl: WORD_W must hold the 31 dB preset");
   end
   if (CYC_PER_WIN < 1) begin : g_bad_win
      $error("step_atten_ctrl: CYC_PER_WIN must be at least 1");
   end

   logic [SYNC_W-1:0] raw_bus, sync_bus;
   logic              le_s;
   logic [1:0]        sel_s;
   logic [WORD_W-1:0] word_s, word_cap;
   logic              le_fall;

   assign raw_bus = {pwr_sel, latch_en, ctrl_word};
   assign {sel_s, le_s, word_s} = sync_bus;

   satt_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .d   (raw_bus),
      .q   (sync_bus)
   );

   satt_edge_align #(.W(WORD_W)) u_align (
      .clk      (clk),
      .le_s     (le_s),
      .word_s   (word_s),
      .le_fall  (le_fall),
      .word_cap (word_cap)
   );

   satt_state_reg #(.W(WORD_W)) u_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .le_s     (le_s),
      .le_fall  (le_fall),
      .word_s   (word_s),
      .word_cap (word_cap),
      .sel_s    (sel_s),
      .state    (atten_state)
   );

   if (CHECK_EN) begin : g_mon
      satt_timing_mon #(.W(WORD_W), .CYC_PER_WIN(CYC_PER_WIN)) u_mon (
         .clk      (clk),
         .rst_n    (rst_n),
         .le_s     (le_s),
         .word_s   (word_s),
         .viol_clr (viol_clr),
         .viol     (timing_viol)
      );
   end else begin : g_no_mon
      assign timing_viol = 1'b0;
   end

   a_r1_reset_state: assert property (@(posedge clk)
      !rst_n |=> (atten_state == '0 && !timing_viol));
endmodule

// File: tb/step_atten_ctrl_tb.sv
module step_atten_ctrl_tb;
   localparam int W   = 6;
   localparam int WIN = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] ctrl_word = '0;
   logic         latch_en = 1'b0;
   logic [1:0]   pwr_sel = 2'b00;
   logic         viol_clr = 1'b0;
   logic [W-1:0] atten_state;
   logic         timing_viol;

   int n_run = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   step_atten_ctrl #(.WORD_W(W), .SYNC_STAGES(2), .CYC_PER_WIN(WIN), .CHECK_EN(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .latch_en(latch_en),
      .pwr_sel(pwr_sel), .viol_clr(viol_clr),
      .atten_state(atten_state), .timing_viol(timing_viol)
   );

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic le, input logic [1:0] sel, input logic [W-1:0] w,
                           input bit chk_rst);
      latch_en = le; pwr_sel = sel; ctrl_word = w; viol_clr = 1'b0;
      rst_n = 1'b0;
      cyc(5);
      if (chk_rst) begin
         check("R1 state in reset", int'(atten_state), 0);
         check("R1 flag in reset", int'(timing_viol), 0);
      end
      rst_n = 1'b1;
      cyc(6);
   endtask

   task automatic clear_flag();
      viol_clr = 1'b1; cyc(1); viol_clr = 1'b0; cyc(1);
   endtask

   task automatic t_presets();
      do_reset(1'b0, 2'b00, 6'b000101, 1'b1);
      check("R2 preset 8 dB", int'(atten_state), 16);
      do_reset(1'b0, 2'b01, 6'b000101, 1'b0);
      check("R3 preset 16 dB", int'(atten_state), 32);
      do_reset(1'b0, 2'b10, 6'b000101, 1'b0);
      check("R3 preset 31 dB", int'(atten_state), 62);
      do_reset(1'b0, 2'b11, 6'b101101, 1'b0);
      check("R4 preset from word", int'(atten_state), 45);
   endtask

   task automatic t_sel_ignored();
      do_reset(1'b0, 2'b00, 6'b000001, 1'b0);
      pwr_sel = 2'b10; cyc(10);
      check("R9 select after boot", int'(atten_state), 16);
      ctrl_word = 6'b110011; cyc(10);
      check("R7 word change while latched", int'(atten_state), 16);
   endtask

   task automatic t_direct();
      do_reset(1'b1, 2'b01, 6'b101010, 1'b0);
      check("R5 boot with strobe high", int'(atten_state), 42);
      ctrl_word = 6'b010101; cyc(3);
      check("R6 direct follow", int'(atten_state), 21);
      ctrl_word = 6'b111111; cyc(3);
      check("R6 direct full scale", int'(atten_state), 63);
   endtask

   task automatic t_short_pulse();
      do_reset(1'b0, 2'b00, 6'b000011, 1'b0);
      latch_en = 1'b1; cyc(1); latch_en = 1'b0; cyc(8);
      check("R10 short strobe flagged", int'(timing_viol), 1);
      cyc(10);
      check("R12 flag sticky", int'(timing_viol), 1);
      clear_flag();
      check("R12 flag cleared", int'(timing_viol), 0);
   endtask

   task automatic t_setup_violation();
      ctrl_word = 6'b000111; cyc(10);
      ctrl_word = 6'b011000; latch_en = 1'b1; cyc(6);
      latch_en = 1'b0; cyc(8);
      check("R11 setup violation", int'(timing_viol), 1);
      check("R6 new word shown in direct", int'(atten_state), 24);
      clear_flag();
   endtask

   task automatic t_hold_capture();
      ctrl_word = 6'b100110; cyc(10);
      latch_en = 1'b1; cyc(6);
      latch_en = 1'b0; ctrl_word = 6'b001001; cyc(8);
      check("R8 capture older word on coincident change", int'(atten_state), 38);
      check("R11 hold violation", int'(timing_viol), 1);
      clear_flag();
   endtask

   task automatic t_clean();
      ctrl_word = 6'b011101; cyc(10);
      latch_en = 1'b1; cyc(6);
      latch_en = 1'b0; cyc(10);
      check("R11 clean transaction no flag", int'(timing_viol), 0);
      check("R8 clean capture", int'(atten_state), 29);
      ctrl_word = 6'b000000; cyc(10);
      check("R7 latched after capture", int'(atten_state), 29);
   endtask

   initial begin
      cyc(2);
      t_presets();
      t_sel_ignored();
      t_direct();
      t_short_pulse();
      t_setup_violation();
      t_hold_capture();
      t_clean();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #2000000;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule